// File: doc/BRIEF.md
# Two-Wire Configuration Register Bank

This block is a slave on a two-wire serial bus (SMBus-style). It gives a bus controller read and write access to a small bank of 8-bit configuration registers. Each register bit drives an on-chip setting, such as an output enable. Every register loads a parameter default at reset, so a system that never uses the bus still gets a working configuration.

The clock and data lines are oversampled with the system clock. The slave pulls the data line low through an open-drain pad, modelled here as an active-low drive enable. The command byte that follows the write address picks the access type:

- **Indexed single-byte access:** command bit 7 is 1, and bits 6:0 give the register offset.
- **Block access:** command bit 7 is 0. The transfer always starts at offset 0 and moves upward one register per byte.

A block write carries a byte count ahead of its data. A block read returns the count first, then the data. Reads use a repeated start with the read address.

Top module: `cfg_smbus_regs`

## Requirements
- R1: The slave acknowledges only the address byte 0xD2 (write) or 0xD3 (read), i.e. 7-bit address 0x69 plus the direction bit. For any other address byte the data line is left released in the acknowledge slot, and the bytes that follow are ignored.
- R2: In the command byte, bit 7 = 1 selects indexed single-byte access at the offset in bits 6:0. Bit 7 = 0 selects block access, which starts at offset 0 whatever bits 6:0 hold.
- R3: A single-byte write (0xD2, command, data) stores the data byte at the offset and acknowledges every byte.
- R4: A single-byte read (0xD2, command, repeated start, 0xD3) returns the register at the offset.
- R5: In a block write, the byte after the command is a count N. The data bytes that follow go to offsets 0, 1, 2 and upward. Data bytes beyond N, or beyond the last register, are acknowledged and discarded.
- R6: A block write stopped after any complete data byte keeps the registers written so far and leaves all others unchanged.
- R7: A block read first returns the register count (8), then registers 0, 1, 2 and upward. After a not-acknowledge from the controller, the slave releases the data line and sends nothing more.
- R8: Single-byte writes to offsets at or above 8 are acknowledged but change no register. Reads at such offsets, and block-read bytes past the last register, return 0x00.
- R9: After reset every register holds its default value, and the data line is released.
- R10: Bytes are shifted most significant bit first in both directions.
- R11: The slave changes its data-line drive only while the synchronized clock is low, and it never drives the line while idle.
- R12: Registers change only on a clock rising edge that completes a data byte, and at most one register changes at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line from the pad |
| sda_i | input | 1 | Serial data line from the pad (wired level) |
| sda_oe_n | output | 1 | Data-line drive enable, active low: 0 pulls the line low |
| cfg_o | output | NUM_REGS*8 | Register contents, register k in bits 8k+7:8k |

## Verification
The assertions assume a well-behaved controller:
- The data line changes only while the clock is low, except at start and stop conditions.
- Each clock phase lasts well over the three-cycle synchronizer delay.
- The controller never aborts with a start or stop while the slave is driving the line.

The bench master holds every phase for five system clocks and changes data only in the low phase. Its random transactions are always complete frames, ended by a stop or by a not-acknowledge followed by a stop. This keeps the stimulus within those assumptions.

// File: rtl/cfg_smbus_regs.sv
module cfg_smbus_regs #(
  parameter int NUM_REGS = 8,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter logic [NUM_REGS*8-1:0] REG_DEFAULTS = 64'h3C00FF810F55A701
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_n,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  localparam int IW = $clog2(NUM_REGS);
  localparam logic [7:0] NREG8 = 8'(NUM_REGS);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic       scl_s, sda_s;
  assign scl_s = scl_sy[1];
  assign sda_s = sda_sy[1];

  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  st_t        st;
  logic [2:0] bitc;
  logic [7:0] sh;
  logic       ackon, mack, rw;
  logic [7:0] bytn;
  logic       cmd_byte;
  logic [6:0] cmd_off;
  logic [7:0] wcount;
  logic [7:0] ridx;
  logic [7:0] regs [NUM_REGS];

  logic [7:0] rx_byte, widx, rprev, rd_data;
  logic       off_ok;
  assign rx_byte = {sh[6:0], sda_s};
  assign widx    = bytn - 8'd3;
  assign rprev   = ridx - 8'd1;
  assign off_ok  = {1'b0, cmd_off} < NREG8;

  always_comb begin
    rd_data = 8'h00;
    if (cmd_byte) begin
      if (off_ok) rd_data = regs[cmd_off[IW-1:0]];
    end else if (ridx == 8'd0) begin
      rd_data = NREG8;
    end else if (ridx <= NREG8) begin
      rd_data = regs[rprev[IW-1:0]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      bitc     <= 3'd0;
      sh       <= 8'h00;
      ackon    <= 1'b0;
      mack     <= 1'b0;
      rw       <= 1'b0;
      bytn     <= 8'd0;
      cmd_byte <= 1'b0;
      cmd_off  <= 7'd0;
      wcount   <= 8'd0;
      ridx     <= 8'd0;
      sda_oe_n <= 1'b1;
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= REG_DEFAULTS[i*8 +: 8];
    end else if (start_c) begin
      st       <= S_RX;
      bitc     <= 3'd0;
      bytn     <= 8'd0;
      ackon    <= 1'b0;
      mack     <= 1'b0;
      sda_oe_n <= 1'b1;
    end else if (stop_c) begin
      st       <= S_IDLE;
      ackon    <= 1'b0;
      mack     <= 1'b0;
      sda_oe_n <= 1'b1;
    end else begin
      case (st)
        S_RX: if (scl_rise) begin
          sh   <= rx_byte;
          bitc <= bitc + 3'd1;
          if (bitc == 3'd7) begin
            if (bytn == 8'd0) begin
              if (rx_byte[7:1] == DEV_ADDR) begin
                rw   <= rx_byte[0];
                bytn <= 8'd1;
                ridx <= 8'd0;
                st   <= S_ACK;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              st <= S_ACK;
              if (!rw) begin
                if (bytn != 8'hFF) bytn <= bytn + 8'd1;
                if (bytn == 8'd1) begin
                  cmd_byte <= rx_byte[7];
                  cmd_off  <= rx_byte[6:0];
                end else if (cmd_byte) begin
                  if (bytn == 8'd2 && off_ok) regs[cmd_off[IW-1:0]] <= rx_byte;
                end else if (bytn == 8'd2) begin
                  wcount <= rx_byte;
                end else if (widx < wcount && widx < NREG8) begin
                  regs[widx[IW-1:0]] <= rx_byte;
                end
              end
            end
          end
        end
        S_ACK: if (scl_fall) begin
          if (!ackon) begin
            ackon    <= 1'b1;
            sda_oe_n <= 1'b0;
          end else begin
            ackon <= 1'b0;
            bitc  <= 3'd0;
            if (rw) begin
              st       <= S_TX;
              sh       <= rd_data;
              sda_oe_n <= rd_data[7];
            end else begin
              st       <= S_RX;
              sda_oe_n <= 1'b1;
            end
          end
        end
        S_TX: if (scl_fall) begin
          bitc <= bitc + 3'd1;
          if (bitc == 3'd7) begin
            sda_oe_n <= 1'b1;
            st       <= S_MACK;
          end else begin
            sda_oe_n <= sh[6];
            sh       <= {sh[6:0], 1'b0};
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            if (sda_s) begin
              st <= S_IDLE;
            end else begin
              mack <= 1'b1;
              if (ridx != 8'hFF) ridx <= ridx + 8'd1;
            end
          end else if (scl_fall && mack) begin
            mack     <= 1'b0;
            bitc     <= 3'd0;
            st       <= S_TX;
            sh       <= rd_data;
            sda_oe_n <= rd_data[7];
          end
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    assign cfg_o[g*8 +: 8] = regs[g];
  end
endmodule

// File: rtl/cfg_smbus_regs_chk.sv
module cfg_smbus_regs_chk #(
  parameter int NUM_REGS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_s,
  input logic                  scl_q,
  input logic                  idle,
  input logic                  sda_oe_n,
  input logic [NUM_REGS*8-1:0] cfg_o
);
  logic [NUM_REGS*8-1:0] cfg_prev;
  logic                  seen;
  logic [NUM_REGS-1:0]   chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_prev <= '0;
      seen     <= 1'b0;
    end else begin
      cfg_prev <= cfg_o;
      seen     <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_chg
    assign chg[g] = cfg_prev[g*8 +: 8] != cfg_o[g*8 +: 8];
  end

  assert_idle_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> sda_oe_n);

  assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_n) |-> !$past(scl_s));

  assert_cfg_on_rise_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o) |-> $past(scl_s && !scl_q));

  assert_one_reg_R12: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> $countones(chg) <= 1);
endmodule

bind cfg_smbus_regs cfg_smbus_regs_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_s),
  .scl_q    (scl_q),
  .idle     (st == S_IDLE),
  .sda_oe_n (sda_oe_n),
  .cfg_o    (cfg_o)
);

// File: tb/cfg_smbus_regs_bench.sv
module cfg_smbus_regs_bench;
  localparam int NR = 8;
  localparam int Q  = 5;
  localparam logic [63:0] DEFS = 64'h3C00FF810F55A701;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe_n;
  logic [NR*8-1:0] cfg_o;
  logic sda_line;
  assign sda_line = sda_m & sda_oe_n;

  always #4 clk = ~clk;

  cfg_smbus_regs u_cfg_smbus_regs (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_n(sda_oe_n), .cfg_o(cfg_o)
  );

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] mdl [NR];
  logic [7:0] dbuf [16];
  logic [7:0] rbuf [16];

  function automatic logic [63:0] flat();
    logic [63:0] f;
    for (int i = 0; i < NR; i++) f[i*8 +: 8] = mdl[i];
    return f;
  endfunction

  function automatic logic [7:0] blk_exp(int k);
    if (k == 0) return 8'(NR);
    if (k - 1 < NR) return mdl[k-1];
    return 8'h00;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitq(int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; waitq(1); scl_m = 1'b1; waitq(1);
    sda_m = 1'b0; waitq(1); scl_m = 1'b0; waitq(1);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; waitq(1); scl_m = 1'b1; waitq(1); sda_m = 1'b1; waitq(2);
  endtask

  task automatic wbit(logic b);
    sda_m = b; waitq(1); scl_m = 1'b1; waitq(2); scl_m = 1'b0; waitq(1);
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; waitq(1); scl_m = 1'b1; waitq(1); b = sda_line;
    waitq(1); scl_m = 1'b0; waitq(1);
  endtask

  task automatic wbyte(logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    ack = !b;
  endtask

  task automatic rbyte(output logic [7:0] d, input bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
    wbit(!ack);
  endtask

  task automatic byte_wr(logic [6:0] off, logic [7:0] d, output bit allack);
    bit a0, a1, a2;
    m_start(); wbyte(8'hD2, a0); wbyte({1'b1, off}, a1); wbyte(d, a2); m_stop();
    allack = a0 & a1 & a2;
    if (off < NR) mdl[off] = d;
  endtask

  task automatic byte_rd(logic [6:0] off, output logic [7:0] d, output bit allack);
    bit a0, a1, a2;
    m_start(); wbyte(8'hD2, a0); wbyte({1'b1, off}, a1);
    m_start(); wbyte(8'hD3, a2); rbyte(d, 1'b0); m_stop();
    allack = a0 & a1 & a2;
  endtask

  task automatic blk_wr(logic [7:0] cmd, logic [7:0] cnt, int nsend, output bit allack);
    bit a;
    allack = 1'b1;
    m_start(); wbyte(8'hD2, a); allack &= a; wbyte(cmd, a); allack &= a;
    wbyte(cnt, a); allack &= a;
    for (int i = 0; i < nsend; i++) begin
      wbyte(dbuf[i], a); allack &= a;
      if (i < cnt && i < NR) mdl[i] = dbuf[i];
    end
    m_stop();
  endtask

  task automatic blk_rd(int n, output bit allack);
    bit a0, a1, a2;
    logic [7:0] d;
    m_start(); wbyte(8'hD2, a0); wbyte(8'h00, a1);
    m_start(); wbyte(8'hD3, a2);
    for (int i = 0; i < n; i++) begin rbyte(d, i != n - 1); rbuf[i] = d; end
    m_stop();
    allack = a0 & a1 & a2;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit ok;
    logic [7:0] d;
    void'($urandom(32'd20061122));
    for (int i = 0; i < NR; i++) mdl[i] = DEFS[i*8 +: 8];
    repeat (5) @(negedge clk);
    chk(cfg_o == DEFS, "R9 defaults", cfg_o, DEFS);
    chk(sda_oe_n == 1'b1, "R9 released", sda_oe_n, 1);
    rst_n = 1'b1;
    waitq(2);

    // R1: foreign addresses get no acknowledge, and nothing changes
    m_start(); wbyte(8'hA4, ok); m_stop();
    chk(!ok, "R1 foreign addr nack", ok, 0);
    m_start(); wbyte(8'hD0, ok); wbyte(8'h80, ok); wbyte(8'h99, ok); m_stop();
    chk(cfg_o == flat(), "R1 foreign frame ignored", cfg_o, flat());

    // R3 R10: single-byte write with an asymmetric value
    byte_wr(7'd3, 8'h01, ok);
    chk(ok, "R3 acks", ok, 1);
    chk(cfg_o[31:24] == 8'h01, "R10 msb first", cfg_o[31:24], 8'h01);
    chk(cfg_o == flat(), "R3 byte write", cfg_o, flat());

    // R4 R1: single-byte read
    byte_rd(7'd4, d, ok);
    chk(ok, "R1 read addr ack", ok, 1);
    chk(d == mdl[4], "R4 byte read", d, mdl[4]);

    // R8: out-of-range offsets
    byte_wr(7'd100, 8'h5A, ok);
    chk(ok && cfg_o == flat(), "R8 oor write discarded", cfg_o, flat());
    byte_rd(7'd9, d, ok);
    chk(d == 8'h00, "R8 oor read zero", d, 0);

    // R2 R5: block write with nonzero low command bits, extra bytes past count
    for (int i = 0; i < 16; i++) dbuf[i] = 8'(8'hC0 + i);
    blk_wr(8'h05, 8'd3, 6, ok);
    chk(ok, "R5 block acks", ok, 1);
    chk(cfg_o == flat(), "R2 R5 block from zero, count limit", cfg_o, flat());

    // R5: count above the bank size
    for (int i = 0; i < 16; i++) dbuf[i] = 8'(8'h10 * i + 3);
    blk_wr(8'h00, 8'd12, 12, ok);
    chk(cfg_o == flat(), "R5 beyond bank discarded", cfg_o, flat());

    // R6: early stop
    for (int i = 0; i < 16; i++) dbuf[i] = 8'(8'hE0 + i);
    blk_wr(8'h00, 8'd8, 2, ok);
    chk(cfg_o == flat(), "R6 early stop", cfg_o, flat());

    // R7 R8: block read past the bank, then release after nack
    blk_rd(11, ok);
    for (int i = 0; i < 11; i++)
      chk(rbuf[i] == blk_exp(i), "R7 block read", rbuf[i], blk_exp(i));
    chk(sda_oe_n == 1'b1, "R7 released after nack", sda_oe_n, 1);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int op;
      op = int'($urandom % 4);
      case (op)
        0: begin
          logic [6:0] off;
          off = 7'($urandom % 12);
          byte_wr(off, 8'($urandom), ok);
          chk(ok && cfg_o == flat(), "R3 random write", cfg_o, flat());
        end
        1: begin
          logic [6:0] off;
          logic [7:0] e;
          off = 7'($urandom % 12);
          e = (off < NR) ? mdl[off] : 8'h00;
          byte_rd(off, d, ok);
          chk(d == e, "R4 random read", d, e);
        end
        2: begin
          int cnt, ns;
          cnt = int'($urandom % 11);
          ns = int'($urandom % 11);
          for (int i = 0; i < 16; i++) dbuf[i] = 8'($urandom);
          blk_wr(8'h00, 8'(cnt), ns, ok);
          chk(ok && cfg_o == flat(), "R6 random block write", cfg_o, flat());
        end
        default: begin
          int n;
          n = 1 + int'($urandom % 11);
          blk_rd(n, ok);
          for (int i = 0; i < n; i++)
            chk(rbuf[i] == blk_exp(i), "R7 random block read", rbuf[i], blk_exp(i));
        end
      endcase
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule